// File: doc/BRIEF.md
# Interrupt Vector Priority Arbiter

This block keeps the per-vector interrupt state of one interrupt controller and decides which vector is offered to the processor. The state is three vectors of 256 bits: pending requests, vectors in service, and a trigger-mode flag for each vector. A higher vector number always means a higher priority. The top four bits of a vector form its priority class.

Requests enter through a set strobe that carries a vector number and a level/edge flag. The processor takes the best request with an acknowledge strobe and retires it with an end-of-interrupt strobe. The block reports three things to the processor. The first is an interrupt line. The second is the vector that an acknowledge would return. The third is the processor priority, formed from a software task priority and from the highest vector in service. Retiring a level-triggered vector produces a one-cycle broadcast pulse that carries that vector. When a request is pending but held back by priority, or when no request can be delivered, an acknowledge returns a programmable spurious vector and leaves the state as it was.

Top module: `vec_prio_arbiter`

## Requirements
- R1: After synchronous reset, irq_o is 0, ppr_o is 0x00, eoi_o is 0 and ack_vec_o is 0xFF. Reset clears all request, in-service and trigger bits and the task priority, and loads the spurious register with 0x0FF: vector 0xFF, enable bit clear.
- R2: A set strobe makes vector set_vec_i pending from the next clock edge. It sets that vector's trigger flag when set_level_i is 1 and clears it when set_level_i is 0.
- R3: When a request is deliverable, ack_vec_o is the highest-numbered pending vector.
- R4: ppr_o equals the task priority when the upper nibble of the task priority is at least the class of the highest in-service vector. Otherwise it equals that class in bits 7:4 with zeros in bits 3:0. An empty in-service set counts as class 0.
- R5: irq_o is 1 exactly when all of these hold: the enable bit is set, a request is pending, and either ppr_o is zero or the class of the top pending vector is strictly greater than ppr_o[7:4].
- R6: When irq_o is 0, ack_vec_o is spurious register bits 7:0, and an acknowledge changes no request or in-service bit.
- R7: An acknowledge while irq_o is 1 clears the top pending bit and sets the same bit in service at the next clock edge.
- R8: End-of-interrupt clears the highest in-service bit. If that vector's trigger flag is set, eoi_o is 1 for exactly the following cycle, with eoi_vec_o equal to that vector. End-of-interrupt with nothing in service, or on an edge vector, gives no pulse.
- R9: A spurious write stores only bits 8:0 of spur_data_i: bits 7:0 are the spurious vector and bit 8 is the enable. With bit 8 clear, irq_o stays 0. Bit 12, the directed end-of-interrupt bit, is dropped, so level vectors still broadcast.
- R10: When set and acknowledge fall in the same cycle, the set is applied after the acknowledge clear, so a set on the acknowledged vector leaves it pending.
- R11: A task priority write takes effect from the next clock edge. irq_o, ack_vec_o and ppr_o follow the stored state with no further register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_req_i | input | 1 | Set-request strobe |
| set_vec_i | input | 8 | Vector to make pending |
| set_level_i | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_data_i | input | 8 | Task priority value |
| spur_wr_i | input | 1 | Spurious/enable register write strobe |
| spur_data_i | input | 16 | Spurious register write data |
| irq_o | output | 1 | A deliverable request exists |
| ack_vec_o | output | 8 | Vector an acknowledge returns now |
| ppr_o | output | 8 | Processor priority |
| eoi_o | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
Two kinds of same-cycle overlap matter here. In the first, a set strobe arrives in the cycle of an acknowledge, sometimes on the very vector being acknowledged. In the second, an end-of-interrupt arrives in the cycle of an acknowledge. The bench provokes both with a directed case that sets and acknowledges the same vector at once, and with random traffic in which all strobes are drawn independently. A bench model applies the end-of-interrupt and acknowledge clears to the old state before it applies the set. It then compares the interrupt line, the acknowledge vector, the processor priority and the broadcast pulse every cycle.

// File: rtl/vpa_pkg.sv
// Package: shared constants of the vector priority arbiter.
// Assumes 8-bit vectors, so the spurious field is 8 bits plus an enable bit.
package vpa_pkg;
    localparam int CLASS_W    = 4;   // priority class = top nibble of a vector
    localparam int SPUR_IN_W  = 16;  // width of the spurious write port
    localparam int SPUR_KEEP  = 9;   // bits retained by the spurious register
    localparam int SPUR_EN    = 8;   // enable bit position inside the register
    localparam logic [SPUR_KEEP-1:0] SPUR_RST = 9'h0FF;
endpackage

// File: rtl/vpa_prio_enc.sv
// Module: highest-set-bit encoder over a wide vector.
// Splits the vector into words, finds the top bit in each word in parallel,
// then picks the highest non-empty word. Assumes at least two words.
module vpa_prio_enc #(
    parameter int WIDTH  = 256,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] top_o
);
    localparam int NWORDS = WIDTH / WORD_W;
    localparam int OFF_W  = $clog2(WORD_W);
    localparam int SEL_W  = IDX_W - OFF_W;

    logic [NWORDS-1:0]            word_any;
    logic [NWORDS-1:0][OFF_W-1:0] word_off;

    // Top bit offset inside one word; lower bits are overwritten by higher ones.
    function automatic logic [OFF_W-1:0] top_in_word(input logic [WORD_W-1:0] w);
        logic [OFF_W-1:0] r;
        r = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (w[b]) r = OFF_W'(b);
        end
        return r;
    endfunction

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        assign word_any[g] = |bits_i[g*WORD_W +: WORD_W];
        assign word_off[g] = top_in_word(bits_i[g*WORD_W +: WORD_W]);
    end

    // Choose the highest word that holds any bit.
    always_comb begin
        top_o   = '0;
        valid_o = |word_any;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) top_o = {SEL_W'(w), word_off[w]};
        end
    end
endmodule

// File: rtl/vpa_ppr_calc.sv
// Module: processor priority and delivery decision.
// Forms the processor priority from the task priority and the top in-service
// vector, then decides whether the top pending vector may be delivered.
module vpa_ppr_calc import vpa_pkg::*; #(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_valid_i,
    input  logic [VEC_W-1:0] isr_top_i,
    input  logic             irr_valid_i,
    input  logic [VEC_W-1:0] irr_top_i,
    input  logic             enable_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             deliver_o
);
    localparam int LOW_W = VEC_W - CLASS_W;

    logic [CLASS_W-1:0] isr_cls;
    logic [CLASS_W-1:0] irr_cls;
    logic               blocked;

    // Processor priority: task priority unless the in-service class is higher.
    always_comb begin
        isr_cls = isr_valid_i ? isr_top_i[VEC_W-1 -: CLASS_W] : '0;
        if (tpr_i[VEC_W-1 -: CLASS_W] >= isr_cls) ppr_o = tpr_i;
        else                                      ppr_o = {isr_cls, {LOW_W{1'b0}}};
    end

    // Delivery: enabled, something pending, and its class beats the priority.
    always_comb begin
        irr_cls   = irr_top_i[VEC_W-1 -: CLASS_W];
        blocked   = (ppr_o != '0) && (irr_cls <= ppr_o[VEC_W-1 -: CLASS_W]);
        deliver_o = enable_i && irr_valid_i && !blocked;
    end
endmodule

// File: rtl/vec_prio_arbiter.sv
// Module: interrupt vector priority arbiter (top).
// Holds the request, in-service and trigger bit vectors, applies set,
// acknowledge and end-of-interrupt strobes on the clock edge, and presents
// the deliverable vector combinationally. Assumes 8-bit vectors.
module vec_prio_arbiter import vpa_pkg::*; #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_req_i,
    input  logic [VEC_W-1:0]     set_vec_i,
    input  logic                 set_level_i,
    input  logic                 ack_i,
    input  logic                 eoi_i,
    input  logic                 tpr_wr_i,
    input  logic [VEC_W-1:0]     tpr_data_i,
    input  logic                 spur_wr_i,
    input  logic [SPUR_IN_W-1:0] spur_data_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     ack_vec_o,
    output logic [VEC_W-1:0]     ppr_o,
    output logic                 eoi_o,
    output logic [VEC_W-1:0]     eoi_vec_o
);
    logic [NUM_VEC-1:0]   irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0]   irr_n, isr_n, tmr_n;
    logic [VEC_W-1:0]     tpr_q;
    logic [SPUR_KEEP-1:0] spur_q;
    logic                 irr_valid, isr_valid, deliver;
    logic [VEC_W-1:0]     irr_top, isr_top;
    logic                 ack_take, eoi_take;

    vpa_prio_enc #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_irr_enc (
        .bits_i(irr_q), .valid_o(irr_valid), .top_o(irr_top)
    );

    vpa_prio_enc #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_isr_enc (
        .bits_i(isr_q), .valid_o(isr_valid), .top_o(isr_top)
    );

    vpa_ppr_calc #(.VEC_W(VEC_W)) u_ppr (
        .tpr_i(tpr_q), .isr_valid_i(isr_valid), .isr_top_i(isr_top),
        .irr_valid_i(irr_valid), .irr_top_i(irr_top),
        .enable_i(spur_q[SPUR_EN]), .ppr_o(ppr_o), .deliver_o(deliver)
    );

    // Processor-facing outputs follow the stored state directly.
    always_comb begin
        irq_o     = deliver;
        ack_vec_o = deliver ? irr_top : spur_q[VEC_W-1:0];
        ack_take  = ack_i && deliver;
        eoi_take  = eoi_i && isr_valid;
    end

    // Next vector state: clears from ack/EOI first, then the set on top.
    always_comb begin
        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        if (eoi_take) isr_n[isr_top] = 1'b0;
        if (ack_take) begin
            irr_n[irr_top] = 1'b0;
            isr_n[irr_top] = 1'b1;
        end
        if (set_req_i) begin
            irr_n[set_vec_i] = 1'b1;
            tmr_n[set_vec_i] = set_level_i;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q     <= '0;
            isr_q     <= '0;
            tmr_q     <= '0;
            tpr_q     <= '0;
            spur_q    <= SPUR_RST;
            eoi_o     <= 1'b0;
            eoi_vec_o <= '0;
        end else begin
            irr_q     <= irr_n;
            isr_q     <= isr_n;
            tmr_q     <= tmr_n;
            if (tpr_wr_i)  tpr_q  <= tpr_data_i;
            if (spur_wr_i) spur_q <= spur_data_i[SPUR_KEEP-1:0];
            eoi_o     <= eoi_take && tmr_q[isr_top];
            eoi_vec_o <= isr_top;
        end
    end

    // R2
    set_marks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req_i |=> irr_q[$past(set_vec_i)] && (tmr_q[$past(set_vec_i)] == $past(set_level_i)));
    // R7
    ack_moves_to_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !(set_req_i && set_vec_i == ack_vec_o))
        |=> isr_q[$past(ack_vec_o)] && !irr_q[$past(ack_vec_o)]);
    // R6
    blocked_ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !set_req_i && !eoi_i) |=> $stable(irr_q) && $stable(isr_q));
    // R8
    eoi_pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |-> $past(eoi_i) && !isr_q[eoi_vec_o] || $past(ack_i));
    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spur_q[SPUR_EN] |-> !irq_o);
    // R4
    ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_o[VEC_W-1 -: CLASS_W] >= tpr_q[VEC_W-1 -: CLASS_W]);
endmodule

// File: tb/tb_vec_prio_arbiter.sv
module tb_vec_prio_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_req_i = 0, set_level_i = 0, ack_i = 0, eoi_i = 0;
    logic        tpr_wr_i = 0, spur_wr_i = 0;
    logic [7:0]  set_vec_i = 0, tpr_data_i = 0;
    logic [15:0] spur_data_i = 0;
    logic        irq_o, eoi_o;
    logic [7:0]  ack_vec_o, ppr_o, eoi_vec_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit [255:0] m_irr, m_isr, m_tmr;
    int m_tpr, m_spur;
    int m_irq, m_ppr, m_ack, m_eoi, m_eoiv;

    vec_prio_arbiter dut (
        .clk(clk), .rst_n(rst_n), .set_req_i(set_req_i), .set_vec_i(set_vec_i),
        .set_level_i(set_level_i), .ack_i(ack_i), .eoi_i(eoi_i),
        .tpr_wr_i(tpr_wr_i), .tpr_data_i(tpr_data_i), .spur_wr_i(spur_wr_i),
        .spur_data_i(spur_data_i), .irq_o(irq_o), .ack_vec_o(ack_vec_o),
        .ppr_o(ppr_o), .eoi_o(eoi_o), .eoi_vec_o(eoi_vec_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int top_of(bit [255:0] v);
        for (int i = 255; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    // Model outputs from the requirements (R3, R4, R5, R6).
    function automatic void model_eval();
        int hr, hs, cls;
        hr = top_of(m_irr);
        hs = top_of(m_isr);
        cls = (hs < 0) ? 0 : (hs >> 4);
        m_ppr = ((m_tpr >> 4) >= cls) ? m_tpr : (cls << 4);
        m_irq = (m_spur[8] && hr >= 0 && !(m_ppr != 0 && (hr >> 4) <= (m_ppr >> 4))) ? 1 : 0;
        m_ack = m_irq ? hr : (m_spur & 8'hFF);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_model();
        model_eval();
        chk("R5", "irq_o", int'(irq_o), m_irq);
        chk("R4", "ppr_o", int'(ppr_o), m_ppr);
        chk("R3", "ack_vec_o", int'(ack_vec_o), m_ack);
        chk("R8", "eoi_o", int'(eoi_o), m_eoi);
        if (m_eoi == 1) chk("R8", "eoi_vec_o", int'(eoi_vec_o), m_eoiv);
    endtask

    // One cycle: drive at negedge, update model at the edge, check at next negedge.
    task automatic step(bit s, int sv, bit lv, bit a, bit e, bit tw, int td, bit sw, int sd);
        int hr, hs;
        bit [255:0] nirr, nisr, ntmr;
        model_eval();
        set_req_i = s; set_vec_i = 8'(sv); set_level_i = lv; ack_i = a; eoi_i = e;
        tpr_wr_i = tw; tpr_data_i = 8'(td); spur_wr_i = sw; spur_data_i = 16'(sd);
        hr = top_of(m_irr);
        hs = top_of(m_isr);
        nirr = m_irr; nisr = m_isr; ntmr = m_tmr;
        m_eoi = 0;
        if (e && hs >= 0) begin
            nisr[hs] = 0;
            m_eoi = m_tmr[hs] ? 1 : 0;
            m_eoiv = hs;
        end
        if (a && m_irq == 1) begin
            nirr[hr] = 0;
            nisr[hr] = 1;
        end
        if (s) begin
            nirr[sv] = 1;
            ntmr[sv] = lv;
        end
        @(posedge clk);
        m_irr = nirr; m_isr = nisr; m_tmr = ntmr;
        if (tw) m_tpr = td & 8'hFF;
        if (sw) m_spur = sd & 16'h1FF;
        @(negedge clk);
        set_req_i = 0; ack_i = 0; eoi_i = 0; tpr_wr_i = 0; spur_wr_i = 0;
        check_model();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd7));
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_spur = 'h0FF; m_eoi = 0; m_eoiv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1", "irq_o", int'(irq_o), 0);
        chk("R1", "ppr_o", int'(ppr_o), 0);
        chk("R1", "ack_vec_o", int'(ack_vec_o), 'hFF);
        chk("R1", "eoi_o", int'(eoi_o), 0);

        // R9 enable with spurious vector 0x0F
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h10F);
        chk("R9", "spurious vector", int'(ack_vec_o), 'h0F);
        // R2 level 0x45 and edge 0x30
        step(1, 'h45, 1, 0, 0, 0, 0, 0, 0);
        step(1, 'h30, 0, 0, 0, 0, 0, 0, 0);
        chk("R3", "top pending", int'(ack_vec_o), 'h45);
        chk("R5", "irq with ppr 0", int'(irq_o), 1);
        // R7 acknowledge moves 0x45 into service
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R7", "ppr after ack", int'(ppr_o), 'h40);
        chk("R6", "blocked gives spurious", int'(ack_vec_o), 'h0F);
        chk("R5", "class 3 blocked", int'(irq_o), 0);
        // R6 blocked ack changes nothing
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R6", "ppr unchanged", int'(ppr_o), 'h40);
        // R8 level EOI broadcasts
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R8", "level broadcast", int'(eoi_o), 1);
        chk("R8", "broadcast vector", int'(eoi_vec_o), 'h45);
        chk("R3", "0x30 offered", int'(ack_vec_o), 'h30);
        idle();
        chk("R8", "pulse one cycle", int'(eoi_o), 0);
        // R11 task priority takes effect next edge
        step(0, 0, 0, 0, 0, 1, 'h35, 0, 0);
        chk("R11", "tpr 0x35 ppr", int'(ppr_o), 'h35);
        chk("R5", "equal class blocked", int'(irq_o), 0);
        step(0, 0, 0, 0, 0, 1, 'h25, 0, 0);
        chk("R5", "lower tpr passes", int'(irq_o), 1);
        // R8 edge EOI gives no pulse, empty EOI nothing
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R8", "edge no broadcast", int'(eoi_o), 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R8", "empty eoi", int'(eoi_o), 0);
        // R10 set and ack of the same vector in one cycle
        step(1, 'h50, 0, 0, 0, 0, 0, 0, 0);
        step(1, 'h50, 0, 1, 0, 0, 0, 0, 0);
        chk("R10", "in service", int'(ppr_o), 'h50);
        chk("R10", "still pending but blocked", int'(irq_o), 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R10", "re-offered", int'(ack_vec_o), 'h50);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R9 disable and bit 12 dropped
        step(1, 'h60, 1, 0, 0, 0, 0, 1, 'h10A3);
        chk("R9", "disabled irq", int'(irq_o), 0);
        chk("R9", "disabled spurious", int'(ack_vec_o), 'hA3);
        step(0, 0, 0, 0, 0, 0, 0, 1, 'h11A3);
        chk("R9", "re-enabled", int'(ack_vec_o), 'h60);
        step(0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R9", "directed bit dropped", int'(eoi_o), 1);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);

        // random traffic, all strobes independent
        for (int c = 0; c < RAND_CYCLES; c++) begin
            bit s, a, e, tw, sw, lv;
            int sv, td, sd;
            s  = ($urandom % 100) < 40;
            a  = ($urandom % 100) < 30;
            e  = ($urandom % 100) < 22;
            tw = ($urandom % 100) < 3;
            sw = ($urandom % 100) < 2;
            lv = $urandom % 2;
            sv = ($urandom % 4 == 0) ? ($urandom % 256) : (16 + $urandom % 240);
            td = ($urandom % 2) ? 0 : ($urandom % 256);
            sd = (($urandom % 10 < 9) ? 'h100 : 0) | ($urandom % 256) | (($urandom % 2) << 12);
            step(s, sv, lv, a, e, tw, td, sw, sd);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule